// File: doc/BRIEF.md
# Load-Use Stall and Taken-Branch Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline and drives the front end's hold and squash lines. When the instruction in execute is a load and its destination register matches one of the registers the decoding instruction reads, the block freezes the program counter and the fetch/decode register for one cycle. In that same cycle it turns the execute-stage control word into a no-op, so an inactive slot moves down the pipe. On the next cycle the load has reached the memory stage, execute holds the no-op, and the waiting instruction continues. The loaded value then reaches it over the forwarding paths, which are not part of this block.

Fetch runs sequentially on the assumption that branches are not taken. Branches resolve in decode. When one resolves as taken, the block asserts a flush that turns the fetch/decode register into a no-op on the next edge, so a taken branch costs one lost cycle. A branch that is itself waiting on a load cannot be trusted that cycle. The stall therefore takes precedence, and the branch is evaluated again once it is released.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: While `rst` is high, and up to the first rising clock edge at which `rst` is sampled low, the outputs are held at `pc_wr_en`=0, `ifid_wr_en`=0, `idex_nop`=1, `ifid_flush`=0.
- R2: When `ex_is_load`=1 and `ex_dest` is nonzero and equal to `id_src_a` or to `id_src_b`, the block stalls in the same cycle: `pc_wr_en`=0, `ifid_wr_en`=0, `idex_nop`=1.
- R3: When `ex_is_load`=0, no stall occurs, whatever the register numbers are.
- R4: Register 0 never causes a stall, even when `ex_is_load`=1 and all three register fields are 0.
- R5: Each source operand is compared on its own. A match on `id_src_a` alone stalls, a match on `id_src_b` alone stalls, and this holds up to the highest register index.
- R6: A load whose destination matches neither source gives no stall: `pc_wr_en`=1, `ifid_wr_en`=1, `idex_nop`=0.
- R7: With `br_taken`=1 and no stall, `ifid_flush`=1 while `pc_wr_en`=1, `ifid_wr_en`=1 and `idex_nop`=0.
- R8: With `br_taken`=1 in a stall cycle, `ifid_flush`=0 and the stall outputs of R2 apply.
- R9: A stall lasts one cycle. Once the no-op has entered execute (`ex_is_load`=0), the held instruction goes ahead with all enables high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ex_is_load | input | 1 | Instruction in execute reads data memory (loads only) |
| ex_dest | input | REG_AW | Destination register of the instruction in execute |
| id_src_a | input | REG_AW | First source register of the instruction in decode |
| id_src_b | input | REG_AW | Second source register of the instruction in decode |
| br_taken | input | 1 | Branch in decode has resolved as taken |
| pc_wr_en | output | 1 | Program counter may update |
| ifid_wr_en | output | 1 | Fetch/decode register may load |
| idex_nop | output | 1 | Zero the control word entering execute |
| ifid_flush | output | 1 | Replace the fetch/decode instruction with a no-op |

## Verification
The bound checker tests the following properties on every clock edge: the reset hold, the stall outputs that any register match with a load produces, the absence of a stall without a load, the immunity of register 0, and the two ways a taken branch is resolved, with and without a concurrent stall. Those properties each look at a single cycle. What only the bench scenarios can show is the two-cycle story of R9, in which a stall followed by the no-op it created lets the held instruction through. They also show the exact cycle at which reset release takes effect, and matches at the top register index.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    // Control word the block hands to the front of the pipeline.
    typedef struct packed {
        logic pc_we;      // program counter may advance
        logic ifid_we;    // fetch/decode register may load
        logic idex_nop;   // zero control entering execute
        logic ifid_flush; // squash fetch/decode instruction
    } front_ctl_t;

    // Held state used while the block is coming out of reset.
    localparam front_ctl_t CTL_HELD = '{pc_we: 1'b0, ifid_we: 1'b0,
                                        idex_nop: 1'b1, ifid_flush: 1'b0};

    // Build the control word from the resolved stall and flush decisions.
    function automatic front_ctl_t ctl_build(input logic stall, input logic flush);
        front_ctl_t c;
        c.pc_we      = ~stall;
        c.ifid_we    = ~stall;
        c.idex_nop   = stall;
        c.ifid_flush = flush;
        return c;
    endfunction

endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
    parameter int  AW        = 5,
    parameter bit  ZERO_HARD = 1'b1
) (
    input  logic [AW-1:0] dest,
    input  logic [AW-1:0] src,
    output logic          hit
);
    generate
        if (ZERO_HARD) begin : g_zero_const
            // register 0 reads as a constant and never depends on a load
            assign hit = (src == dest) && (|src);
        end else begin : g_zero_plain
            assign hit = (src == dest);
        end
    endgenerate
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                     is_load,
    input  logic [AW-1:0]            dest,
    input  logic [NSRC-1:0][AW-1:0]  srcs,
    output logic                     stall
);
    logic [NSRC-1:0] hits;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            hz_src_cmp #(.AW(AW), .ZERO_HARD(1'b1)) u_cmp (
                .dest (dest),
                .src  (srcs[i]),
                .hit  (hits[i])
            );
        end
    endgenerate

    // only loads assert the memory-read flag, so only loads stall
    assign stall = is_load && (|hits);
endmodule

// File: rtl/hz_flush.sv
module hz_flush (
    input  logic br_taken,
    input  logic stall,
    output logic flush
);
    // a branch waiting on a load has stale operands; let the stall win
    assign flush = br_taken && !stall;
endmodule

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl
    import hzc_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] ex_dest,
    input  logic [REG_AW-1:0] id_src_a,
    input  logic [REG_AW-1:0] id_src_b,
    input  logic              br_taken,
    output logic              pc_wr_en,
    output logic              ifid_wr_en,
    output logic              idex_nop,
    output logic              ifid_flush
);
    localparam int NSRC = 2;

    logic                        run_q;
    logic                        stall;
    logic                        flush;
    logic [NSRC-1:0][REG_AW-1:0] srcs;
    front_ctl_t                  ctl;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= 1'b1;
    end

    assign srcs = {id_src_b, id_src_a};

    hz_loaduse #(.AW(REG_AW), .NSRC(NSRC)) u_lu (
        .is_load (ex_is_load),
        .dest    (ex_dest),
        .srcs    (srcs),
        .stall   (stall)
    );

    hz_flush u_fl (
        .br_taken (br_taken),
        .stall    (stall),
        .flush    (flush)
    );

    always_comb begin
        if (!run_q || rst) ctl = CTL_HELD;
        else               ctl = ctl_build(stall, flush);
    end

    assign pc_wr_en   = ctl.pc_we;
    assign ifid_wr_en = ctl.ifid_we;
    assign idex_nop   = ctl.idex_nop;
    assign ifid_flush = ctl.ifid_flush;
endmodule

// File: rtl/hz_stall_chk.sv
module hz_stall_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          run_q,
    input logic          ex_is_load,
    input logic [AW-1:0] ex_dest,
    input logic [AW-1:0] id_src_a,
    input logic [AW-1:0] id_src_b,
    input logic          br_taken,
    input logic          pc_wr_en,
    input logic          ifid_wr_en,
    input logic          idex_nop,
    input logic          ifid_flush
);
    logic dep;
    assign dep = ex_is_load && (ex_dest != '0) &&
                 (ex_dest == id_src_a || ex_dest == id_src_b);

    p_held_until_run_r1: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (!pc_wr_en && !ifid_wr_en && idex_nop && !ifid_flush));

    p_stall_on_dep_r2: assert property (@(posedge clk) disable iff (rst)
        (run_q && dep) |-> (!pc_wr_en && !ifid_wr_en && idex_nop));

    p_no_load_no_stall_r3: assert property (@(posedge clk) disable iff (rst)
        (run_q && !ex_is_load) |-> (pc_wr_en && ifid_wr_en && !idex_nop));

    p_reg_zero_free_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && ex_dest == '0) |-> (pc_wr_en && !idex_nop));

    p_flush_taken_r7: assert property (@(posedge clk) disable iff (rst)
        (run_q && br_taken && !dep) |-> (ifid_flush && pc_wr_en && ifid_wr_en));

    p_stall_beats_flush_r8: assert property (@(posedge clk) disable iff (rst)
        (run_q && br_taken && dep) |-> (!ifid_flush && idex_nop));
endmodule

bind hazard_stall_ctrl hz_stall_chk #(.AW(REG_AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run_q      (run_q),
    .ex_is_load (ex_is_load),
    .ex_dest    (ex_dest),
    .id_src_a   (id_src_a),
    .id_src_b   (id_src_b),
    .br_taken   (br_taken),
    .pc_wr_en   (pc_wr_en),
    .ifid_wr_en (ifid_wr_en),
    .idex_nop   (idex_nop),
    .ifid_flush (ifid_flush)
);

// File: tb/sim_hazard_stall_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_stall_ctrl;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ex_is_load = 1'b0;
    logic [AW-1:0] ex_dest = '0;
    logic [AW-1:0] id_src_a = '0;
    logic [AW-1:0] id_src_b = '0;
    logic          br_taken = 1'b0;
    logic          pc_wr_en, ifid_wr_en, idex_nop, ifid_flush;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hazard_stall_ctrl #(.REG_AW(AW)) u0 (
        .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_dest(ex_dest),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .br_taken(br_taken),
        .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
        .idex_nop(idex_nop), .ifid_flush(ifid_flush)
    );

    // {req[3:0], load, dest[4:0], src_a[4:0], src_b[4:0], br, exp{pc,ifid,nop,flush}}
    localparam int NV = 11;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2, 1'b1, 5'd5,  5'd5,  5'd7,  1'b0, 4'b0010},  // R2 match on a
        {4'd5, 1'b1, 5'd7,  5'd5,  5'd7,  1'b0, 4'b0010},  // R5 match on b only
        {4'd6, 1'b1, 5'd9,  5'd5,  5'd7,  1'b0, 4'b1100},  // R6 no match
        {4'd3, 1'b0, 5'd5,  5'd5,  5'd5,  1'b0, 4'b1100},  // R3 not a load
        {4'd4, 1'b1, 5'd0,  5'd0,  5'd0,  1'b0, 4'b1100},  // R4 register 0
        {4'd7, 1'b0, 5'd3,  5'd1,  5'd2,  1'b1, 4'b1101},  // R7 taken branch
        {4'd8, 1'b1, 5'd4,  5'd4,  5'd0,  1'b1, 4'b0010},  // R8 stall beats flush
        {4'd5, 1'b1, 5'd31, 5'd0,  5'd31, 1'b0, 4'b0010},  // R5 top index on b
        {4'd5, 1'b1, 5'd31, 5'd31, 5'd3,  1'b0, 4'b0010},  // R5 top index on a
        {4'd7, 1'b1, 5'd31, 5'd30, 5'd1,  1'b1, 4'b1101},  // R7 load, no dep, taken
        {4'd3, 1'b0, 5'd0,  5'd0,  5'd0,  1'b0, 4'b1100}   // R3 idle
    };

    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {pc_wr_en, ifid_wr_en, idex_nop, ifid_flush};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (pc,ifid,nop,flush)", tag, act, exp);
        end
    endtask

    task automatic drive(input logic ld, input logic [AW-1:0] d, input logic [AW-1:0] a,
                         input logic [AW-1:0] b, input logic br);
        @(negedge clk);
        ex_is_load = ld; ex_dest = d; id_src_a = a; id_src_b = b; br_taken = br;
        #1;
    endtask

    initial begin
        // R1: held during reset even with a would-be branch
        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b1);
        check("R1 in reset", 4'b0010);
        drive(1'b0, 5'd0, 5'd0, 5'd0, 1'b0);
        check("R1 in reset later", 4'b0010);
        // release between edges: still held until next rising edge
        @(negedge clk); rst = 1'b0; #1;
        check("R1 after release, before edge", 4'b0010);
        @(negedge clk); #1;
        check("R1 running", 4'b1100);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            drive(v[20], v[19:15], v[14:10], v[9:5], v[4]);
            check($sformatf("R%0d vector %0d", v[24:21], i), v[3:0]);
        end

        // R9: stall then the no-op in execute lets the held instruction through
        drive(1'b1, 5'd12, 5'd12, 5'd2, 1'b0);
        check("R9 stall cycle", 4'b0010);
        drive(1'b0, 5'd0, 5'd12, 5'd2, 1'b0);
        check("R9 released cycle", 4'b1100);

        // R8 then R7: branch waiting on load flushes once released
        drive(1'b1, 5'd8, 5'd8, 5'd8, 1'b1);
        check("R8 branch held by stall", 4'b0010);
        drive(1'b0, 5'd0, 5'd8, 5'd8, 1'b1);
        check("R7 branch resolves after stall", 4'b1101);

        // R1 again: mid-run reset forces held state
        @(negedge clk); rst = 1'b1; ex_is_load = 1'b0; br_taken = 1'b1; #1;
        check("R1 reset re-asserted", 4'b0010);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule